// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a stream of bytes into a bit-oriented HDLC frame and drives it out one bit per clock on a single serial line. The user raises a request with the first byte on the bus. The block sends a full opening flag (0x7E) and then pulls payload bytes one at a time through a single-cycle take strobe. The user marks the final byte with an end marker. The block then appends a 16-bit frame check sequence and a closing flag.

Inside the frame body, which covers the payload and the FCS, the block inserts a zero after any run of five ones, so a flag cannot appear there by accident. Flags themselves are never stuffed. Between frames the line carries either continuous ones or back-to-back flags, selected by an input. This choice also sets how long a request waits before its first byte is taken.

Top module: `hdlc_framer_tx`

## Requirements
- R1: Every frame starts with a complete flag, bits 0,1,1,1,1,1,1,0 on the line (0x7E), directly before the first payload bit. It ends with the same eight bits directly after the last FCS bit, or after the zero stuffed behind that bit. Flag bits are never stuffed.
- R2: Inside the frame body (payload and FCS), a 0 is placed on the line immediately after every fifth consecutive 1. The run count starts at zero at the beginning of each body and restarts after each inserted 0. It carries over from the payload into the FCS.
- R3: `byte_take` is high for exactly one cycle per byte. The byte on `data_in` is captured at the clock edge that ends that cycle. For the first byte, that cycle is the last bit of the opening flag. For later bytes, it is the last bit of the previous byte. The line shows no gap between bytes other than stuffed zeros.
- R4: Payload bytes are sent least significant bit first.
- R5: The FCS uses generator polynomial x^16+x^15+x^2+1 (0x8005). The register starts at 0x0000 and is updated with each unstuffed payload bit in line order. Its 16 bits are then sent most significant bit first.
- R6: With `idle_ones`=1, the line is 1 between frames. The first `byte_take` comes exactly 8 cycles after the first cycle in which `data_valid` is high.
- R7: With `idle_ones`=0, the line repeats whole flags between frames. The idle flag sequence restarts at its first bit right after a closing flag and right after reset. The first `byte_take` comes 8 to 15 cycles after `data_valid` rises, so every idle flag is sent whole.
- R8: When the byte captured with `last_byte`=1 has been sent, no further `byte_take` occurs in that frame. The FCS follows at once, and the number of takes equals the number of bytes.
- R9: The synchronous reset `rst` ends any frame in progress and returns the block to idle. `byte_take` stays low and the line follows the selected idle pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| idle_ones | input | 1 | Idle pattern select: 1 = continuous ones, 0 = repeated flags |
| data_valid | input | 1 | Request to start a frame; first byte is on `data_in` |
| data_in | input | 8 | Payload byte offered to the block |
| last_byte | input | 1 | Marks the byte on `data_in` as the final byte of the frame |
| byte_take | output | 1 | One-cycle strobe; `data_in` and `last_byte` are captured at the end of this cycle |
| ser_out | output | 1 | Serial line output |

## Verification
The assertions take for granted that the user keeps `data_valid` high from the request until the first take. They also assume a correct byte and end marker are on the bus in every cycle where `byte_take` is high. They further assume `idle_ones` does not change while a frame is in flight, and that reset is held for more than one cycle. The bench keeps within these limits in three ways. It raises the request together with the first byte. It replaces the byte only on the falling edge after the edge that consumed it. It changes the idle mode only while the line is idle.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int FLAG_LEN = 8;
    localparam int FIDX_W   = $clog2(FLAG_LEN);
    localparam logic [FLAG_LEN-1:0] FLAG_PATTERN = 8'h7E;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_OPEN,
        TX_BODY,
        TX_FCS,
        TX_CLOSE
    } tx_state_e;

    // Per-cycle control word produced by the sequencer
    typedef struct packed {
        logic take;        // byte capture strobe
        logic body_start;  // first body bit follows
        logic crc_update;  // fold line bit into the check register
        logic crc_shift;   // move check register toward the line
        logic run_active;  // cycle belongs to the stuffed region
        logic line_bit;    // value on the serial line
    } tx_ctrl_s;

    // Flag bit for a given position, sent least significant bit first
    function automatic logic flag_bit(input logic [FIDX_W-1:0] idx);
        return FLAG_PATTERN[idx];
    endfunction

endpackage

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic active,
    input  logic sent_bit,
    output logic stuff_now,
    output logic near_run
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] ones_q;

    assign stuff_now = (ones_q == CW'(RUN_LEN));
    assign near_run  = (ones_q == CW'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ones_q <= '0;
        end else if (active) begin
            if (stuff_now) begin
                ones_q <= '0;
            end else if (sent_bit) begin
                ones_q <= ones_q + 1'b1;
            end else begin
                ones_q <= '0;
            end
        end
    end

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h8005
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic update,
    input  logic shift,
    input  logic din,
    output logic msb
);
    logic [W-1:0] crc_q;
    logic [W-1:0] nxt_upd;
    logic         fb;

    assign fb         = din ^ crc_q[W-1];
    assign nxt_upd[0] = fb & POLY[0];

    for (genvar i = 1; i < W; i++) begin : g_tap
        assign nxt_upd[i] = crc_q[i-1] ^ (fb & POLY[i]);
    end

    assign msb = crc_q[W-1];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= '0;
        end else if (update) begin
            crc_q <= nxt_upd;
        end else if (shift) begin
            crc_q <= {crc_q[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle_ones,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    input  logic              last_byte,
    input  logic              stuff_now,
    input  logic              near_run,
    input  logic              crc_msb,
    output tx_ctrl_s          ctl,
    output tx_state_e         state_o
);
    localparam int MAXC      = (CRC_W > DATA_W) ? CRC_W : DATA_W;
    localparam int CNT_W     = $clog2(MAXC + 1);
    localparam int FLAG_LAST = FLAG_LEN - 1;

    tx_state_e         st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              last_q;
    logic              flag_end;
    logic              byte_end;

    assign flag_end = (cnt_q == CNT_W'(FLAG_LAST));
    assign byte_end = (cnt_q == CNT_W'(DATA_W - 1));
    assign state_o  = st_q;

    always_comb begin
        ctl = '0;
        unique case (st_q)
            TX_IDLE: begin
                ctl.line_bit = idle_ones ? 1'b1 : flag_bit(cnt_q[FIDX_W-1:0]);
            end
            TX_OPEN: begin
                ctl.line_bit   = flag_bit(cnt_q[FIDX_W-1:0]);
                ctl.take       = flag_end;
                ctl.body_start = flag_end;
            end
            TX_BODY: begin
                ctl.run_active = 1'b1;
                if (stuff_now) begin
                    ctl.line_bit = 1'b0;
                end else begin
                    ctl.line_bit   = shreg_q[0];
                    ctl.crc_update = 1'b1;
                    ctl.take       = byte_end && !last_q;
                end
            end
            TX_FCS: begin
                ctl.run_active = 1'b1;
                ctl.line_bit   = stuff_now ? 1'b0 : crc_msb;
                ctl.crc_shift  = !stuff_now;
            end
            TX_CLOSE: begin
                ctl.line_bit = flag_bit(cnt_q[FIDX_W-1:0]);
            end
            default: ctl = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= TX_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            last_q  <= 1'b0;
        end else begin
            unique case (st_q)
                TX_IDLE: begin
                    cnt_q <= flag_end ? '0 : cnt_q + 1'b1;
                    if (data_valid && (idle_ones || flag_end)) begin
                        st_q  <= TX_OPEN;
                        cnt_q <= '0;
                    end
                end
                TX_OPEN: begin
                    if (flag_end) begin
                        st_q    <= TX_BODY;
                        cnt_q   <= '0;
                        shreg_q <= data_in;
                        last_q  <= last_byte;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TX_BODY: begin
                    if (!stuff_now) begin
                        if (byte_end) begin
                            cnt_q <= '0;
                            if (last_q) begin
                                st_q <= TX_FCS;
                            end else begin
                                shreg_q <= data_in;
                                last_q  <= last_byte;
                            end
                        end else begin
                            cnt_q   <= cnt_q + 1'b1;
                            shreg_q <= shreg_q >> 1;
                        end
                    end
                end
                TX_FCS: begin
                    if (stuff_now) begin
                        if (cnt_q == CNT_W'(CRC_W)) begin
                            st_q  <= TX_CLOSE;
                            cnt_q <= '0;
                        end
                    end else if (cnt_q == CNT_W'(CRC_W - 1)) begin
                        if (near_run && crc_msb) begin
                            cnt_q <= CNT_W'(CRC_W);
                        end else begin
                            st_q  <= TX_CLOSE;
                            cnt_q <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TX_CLOSE: begin
                    if (flag_end) begin
                        st_q  <= TX_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= TX_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/hdlc_framer_tx.sv
module hdlc_framer_tx
    import hdlc_tx_pkg::*;
#(
    parameter int               DATA_W   = 8,
    parameter int               CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h8005,
    parameter int               RUN_LEN  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle_ones,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    input  logic              last_byte,
    output logic              byte_take,
    output logic              ser_out
);
    tx_ctrl_s  ctl;
    tx_state_e state_w;
    logic      stuff_now;
    logic      near_run;
    logic      crc_msb;

    hdlc_tx_ctrl #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .idle_ones  (idle_ones),
        .data_valid (data_valid),
        .data_in    (data_in),
        .last_byte  (last_byte),
        .stuff_now  (stuff_now),
        .near_run   (near_run),
        .crc_msb    (crc_msb),
        .ctl        (ctl),
        .state_o    (state_w)
    );

    hdlc_tx_stuffer #(
        .RUN_LEN (RUN_LEN)
    ) u_stuff (
        .clk       (clk),
        .rst       (rst),
        .clear     (ctl.body_start),
        .active    (ctl.run_active),
        .sent_bit  (ctl.line_bit),
        .stuff_now (stuff_now),
        .near_run  (near_run)
    );

    hdlc_tx_fcs #(
        .W    (CRC_W),
        .POLY (CRC_POLY)
    ) u_fcs (
        .clk    (clk),
        .rst    (rst),
        .clear  (ctl.body_start),
        .update (ctl.crc_update),
        .shift  (ctl.crc_shift),
        .din    (ctl.line_bit),
        .msb    (crc_msb)
    );

    assign byte_take = ctl.take;
    assign ser_out   = ctl.line_bit;

endmodule

// File: rtl/hdlc_framer_tx_chk.sv
module hdlc_framer_tx_chk
    import hdlc_tx_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input logic      clk,
    input logic      rst,
    input logic      idle_ones,
    input logic      byte_take,
    input logic      ser_out,
    input tx_state_e st
);
    logic [3:0] run_q;
    logic [3:0] run_next;
    logic       in_body;

    assign in_body  = (st == TX_BODY) || (st == TX_FCS);
    assign run_next = ser_out ? ((run_q == 4'hF) ? 4'hF : run_q + 4'd1) : 4'd0;

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_next;
    end

    assert_take_single_R3: assert property (@(posedge clk) disable iff (rst)
        byte_take |=> !byte_take);

    assert_take_to_body_R3: assert property (@(posedge clk) disable iff (rst)
        byte_take |=> (st == TX_BODY));

    assert_run_limit_R2: assert property (@(posedge clk) disable iff (rst)
        in_body |-> (run_next <= 4'(RUN_LEN)));

    assert_idle_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (st == TX_IDLE && idle_ones) |-> ser_out);

    assert_open_tail_R1: assert property (@(posedge clk) disable iff (rst)
        (st == TX_BODY && $past(st) == TX_OPEN) |-> (!$past(ser_out) && $past(ser_out, 2)));

    assert_fcs_to_close_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == TX_FCS && st != TX_FCS) |-> (st == TX_CLOSE));

endmodule

bind hdlc_framer_tx hdlc_framer_tx_chk #(
    .RUN_LEN (RUN_LEN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .idle_ones (idle_ones),
    .byte_take (byte_take),
    .ser_out   (ser_out),
    .st        (state_w)
);

// File: tb/hdlc_framer_tx_test.sv
module hdlc_framer_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idle_ones = 1'b1;
    logic       data_valid = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       last_byte = 1'b0;
    logic       byte_take;
    logic       ser_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // {idle_ones, count-1 (3 bits), byte3, byte2, byte1, byte0}
    localparam logic [35:0] VEC [8] = '{
        {1'b1, 3'd0, 32'h0000_005A},
        {1'b1, 3'd3, 32'hFFFF_FFFF},
        {1'b0, 3'd1, 32'h0000_7E7E},
        {1'b0, 3'd2, 32'h0080_0100},
        {1'b1, 3'd1, 32'h0000_F81F},
        {1'b0, 3'd3, 32'hC33C_0FF0},
        {1'b1, 3'd2, 32'h00FF_3E7C},
        {1'b0, 3'd0, 32'h0000_00FF}
    };

    bit exp_bits [0:511];
    int exp_len;
    bit rec [0:511];
    int run_ones;

    hdlc_framer_tx uut (
        .clk        (clk),
        .rst        (rst),
        .idle_ones  (idle_ones),
        .data_valid (data_valid),
        .data_in    (data_in),
        .last_byte  (last_byte),
        .byte_take  (byte_take),
        .ser_out    (ser_out)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
                finish_run();
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int got, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic push_raw(input bit b);
        exp_bits[exp_len] = b;
        exp_len++;
    endtask

    task automatic push_body(input bit b);
        push_raw(b);
        run_ones = b ? run_ones + 1 : 0;
        if (run_ones == 5) begin
            push_raw(1'b0);
            run_ones = 0;
        end
    endtask

    task automatic push_flag();
        for (int i = 0; i < 8; i++) push_raw((i != 0) && (i != 7));
    endtask

    // Expected line image of one frame built from the requirements
    task automatic build_frame(input logic [31:0] bytes, input int n);
        logic [15:0] crc;
        bit          b;
        exp_len  = 0;
        run_ones = 0;
        crc      = 16'h0000;
        push_flag();
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) begin
                b   = bytes[8*k + i];
                crc = {crc[14:0], 1'b0} ^ ((b ^ crc[15]) ? 16'h8005 : 16'h0000);
                push_body(b);
            end
        end
        for (int i = 15; i >= 0; i--) push_body(crc[i]);
        push_flag();
    endtask

    task automatic run_frame(input int id, input bit mode, input int n, input logic [31:0] bytes);
        int  idx;
        int  t0;
        int  takes;
        int  start;
        int  bad;
        int  stop;
        bit  took;
        bit  idle_ok;
        @(negedge clk);
        idle_ones = mode;
        repeat (11) @(negedge clk);
        build_frame(bytes, n);
        idx   = 0;
        t0    = -1;
        takes = 0;
        took  = 1'b0;
        stop  = 500;
        for (int cyc = 0; cyc < 500 && cyc < stop; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (cyc == 0) begin
                data_valid = 1'b1;
                data_in    = bytes[7:0];
                last_byte  = (n == 1);
            end else if (took) begin
                idx++;
                if (idx < n) begin
                    data_in   = bytes[8*idx +: 8];
                    last_byte = (idx == n - 1);
                end else begin
                    data_valid = 1'b0;
                    data_in    = 8'h00;
                    last_byte  = 1'b0;
                end
            end
            rec[cyc] = ser_out;
            took     = byte_take;
            if (took) begin
                takes++;
                if (t0 < 0) begin
                    t0   = cyc;
                    stop = t0 - 7 + exp_len + 8;
                end
            end
        end
        data_valid = 1'b0;
        if (mode) check(t0 == 8, $sformatf("R6 frame %0d first-take latency", id), t0, 8);
        else      check(t0 >= 8 && t0 <= 15, $sformatf("R7 frame %0d first-take latency", id), t0, 8);
        check(takes == n, $sformatf("R3/R8 frame %0d take count", id), takes, n);
        start = t0 - 7;
        bad   = -1;
        for (int i = 0; i < exp_len; i++) begin
            if (bad < 0 && rec[start + i] != exp_bits[i]) bad = i;
        end
        if (bad < 0) begin
            check(1'b1, "R1/R2/R4/R5 line image", 0, 0);
        end else begin
            check(1'b0, $sformatf("R1/R2/R4/R5 frame %0d line bit %0d", id, bad),
                  int'(rec[start + bad]), int'(exp_bits[bad]));
        end
        idle_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (rec[start + exp_len + i] != (mode ? 1'b1 : ((i != 0) && (i != 7)))) idle_ok = 1'b0;
        end
        check(idle_ok, $sformatf("R6/R7 frame %0d idle after close", id), int'(idle_ok), 1);
    endtask

    initial begin
        bit ok;
        // Reset state with ones idle
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (ser_out !== 1'b1 || byte_take !== 1'b0) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R9/R6 reset idle ones", int'(ok), 1);

        // Reset restarts the flag idle sequence at its first bit
        idle_ones = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (i > 0) @(negedge clk);
            if (ser_out !== (((i % 8) != 0) && ((i % 8) != 7))) ok = 1'b0;
        end
        check(ok, "R7/R9 idle flags after reset", int'(ok), 1);

        // Main table
        for (int v = 0; v < 8; v++) begin
            run_frame(v, VEC[v][35], int'(VEC[v][34:32]) + 1, VEC[v][31:0]);
        end

        // Reset in the middle of a frame
        @(negedge clk);
        idle_ones  = 1'b1;
        data_valid = 1'b1;
        data_in    = 8'hFF;
        last_byte  = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst        = 1'b0;
        data_valid = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            if (ser_out !== 1'b1 || byte_take !== 1'b0) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R9 mid-frame reset returns to idle", int'(ok), 1);

        // Recovery after the abort
        run_frame(8, 1'b1, 2, 32'h0000_7EFF);

        finish_run();
    end

endmodule